// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block produces the bit timing of a CAN controller. It is advanced by a time-quantum tick that comes from an upstream prescaler. Each bit is built from a sync quantum, a programmable first phase segment and a programmable second phase segment. The block raises a sample strobe at the boundary between the two phase segments and a bit-start strobe whenever a new sync quantum begins. The received line is sampled once per quantum. Recessive-to-dominant transitions between consecutive quantum samples serve as synchronization edges.

While the frame-start qualifier is high, any falling edge hard-synchronizes the bit: the quantum that holds the edge becomes the sync quantum. At other times an edge resynchronizes the bit, at most once per bit. The block finds the signed phase error of the edge relative to the sync quantum. For a positive error it stretches the first phase segment, and for a negative error it trims the second phase segment. The size of either adjustment is limited to the jump width. In triple-sample mode the sampled bit is a 2-of-3 vote over the last three quantum samples.

Top module: `can_bit_sync`

## Requirements
- R1: After a synchronous reset, `smp_strobe` and `bit_start` are low and `smp_bit` is 1 (recessive). The timing starts in the sync quantum.
- R2: With no falling edge, every bit lasts 1 + (cfg_seg1+1) + (cfg_seg2+1) quanta. The sample strobe marks the tick that follows the first 1 + (cfg_seg1+1) quanta of a bit. Each field holds the segment length minus one. The jump width is cfg_sjw+1 quanta.
- R3: A tick that sees a falling edge (previous quantum sample 1, current sample 0) while `sof_window` is high makes that quantum the sync quantum, wherever the edge falls in the bit.
- R4: With `sof_window` low, an edge at position e of the first phase segment (1 = its first quantum), where e is at most the jump width, moves the sample point e quanta later.
- R5: An edge in the first phase segment with e greater than the jump width moves the sample point exactly one jump width later.
- R6: An edge that falls in the second phase segment, with r quanta of the segment still to run (counting the edge quantum) and r at most the jump width, makes that quantum the sync quantum of the next bit.
- R7: An edge in the second phase segment with r greater than the jump width shortens that segment by one jump width.
- R8: Within one bit, only the first resynchronizing edge acts. Later edges in the same bit leave its timing unchanged.
- R9: Rising edges, and falling edges that land on the sync quantum, leave the timing unchanged.
- R10: At each sample strobe, `smp_bit` takes the rx sample of that tick when `cfg_triple` is 0, or the majority of the samples of that tick and the two before it when `cfg_triple` is 1. Otherwise it holds its value.
- R11: Both strobes are registered. They appear in the clock cycle after the tick that causes them and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tq_tick | input | 1 | One-cycle time-quantum pulse |
| cfg_seg1 | input | SEG1_W | First phase segment length minus one |
| cfg_seg2 | input | SEG2_W | Second phase segment length minus one |
| cfg_sjw | input | SJW_W | Jump width minus one |
| cfg_triple | input | 1 | Triple-sample majority mode |
| rx | input | 1 | Received bus level (1 = recessive) |
| sof_window | input | 1 | Hard synchronization allowed (bus idle / frame start) |
| smp_strobe | output | 1 | Sample-point pulse |
| smp_bit | output | 1 | Sampled bit value |
| bit_start | output | 1 | Sync-quantum (bit boundary) pulse |

## Verification
The bench builds the block with a 3-bit first-segment field, giving 1 to 8 quanta, and keeps the default widths of the other fields. This makes a full sweep possible: every first and second segment length, every jump width, and both sample modes, over all settings that meet the minimum segment-2 rules. For each setting, a pseudo-random rx stream places falling edges at every position in the bit. This covers both signs of phase error, both sides of the jump-width clamp, repeated edges within one bit, and edges while hard synchronization is enabled.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } bt_phase_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx,
  input  logic triple,
  output logic fall,
  output logic level
);

  logic hist1_q, hist2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1_q <= 1'b1;
      hist2_q <= 1'b1;
    end else if (tick) begin
      hist1_q <= rx;
      hist2_q <= hist1_q;
    end
  end

  always_comb begin
    fall  = hist1_q & ~rx;
    level = triple ? vote3(rx, hist1_q, hist2_q) : rx;
  end

endmodule

// File: rtl/can_bt_phase.sv
module can_bt_phase
  import can_bt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fall,
  input  logic              hard_ok,
  input  logic [SEG1_W-1:0] cfg_seg1,
  input  logic [SEG2_W-1:0] cfg_seg2,
  input  logic [SJW_W-1:0]  cfg_sjw,
  output logic              go_sync,
  output logic              go_sample,
  output bt_phase_e         phase_o
);

  localparam int CNT_W = ((SEG1_W > SEG2_W) ? SEG1_W : SEG2_W) + 2;
  localparam int EXT_W = SJW_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  bt_phase_e        phase_q, nrm_phase, fin_phase;
  logic [CNT_W-1:0] cnt_q, nrm_cnt, fin_cnt;
  logic [EXT_W-1:0] ext_q, fin_ext, shr_q, fin_shr;
  logic             done_q, fin_done;
  logic [CNT_W-1:0] len1, len2, jw, err_pos, err_left;

  always_comb begin
    jw       = CNT_W'(cfg_sjw) + ONE;
    len1     = CNT_W'(cfg_seg1) + ONE + CNT_W'(ext_q);
    len2     = CNT_W'(cfg_seg2) + ONE - CNT_W'(shr_q);

    nrm_phase = phase_q;
    nrm_cnt   = cnt_q + ONE;
    unique case (phase_q)
      PH_SYNC: begin
        nrm_phase = PH_SEG1;
        nrm_cnt   = '0;
      end
      PH_SEG1: if (cnt_q == len1 - ONE) begin
        nrm_phase = PH_SEG2;
        nrm_cnt   = '0;
      end
      default: if (cnt_q == len2 - ONE) begin
        nrm_phase = PH_SYNC;
        nrm_cnt   = '0;
      end
    endcase

    err_pos  = nrm_cnt + ONE;
    err_left = len2 - nrm_cnt;

    fin_phase = nrm_phase;
    fin_cnt   = nrm_cnt;
    fin_ext   = ext_q;
    fin_shr   = shr_q;
    fin_done  = done_q;
    if (fall && hard_ok) begin
      fin_phase = PH_SYNC;
      fin_cnt   = '0;
    end else if (fall && !done_q && nrm_phase != PH_SYNC) begin
      fin_done = 1'b1;
      if (nrm_phase == PH_SEG1) begin
        fin_ext = (err_pos > jw) ? EXT_W'(jw) : EXT_W'(err_pos);
      end else if (err_left <= jw) begin
        fin_phase = PH_SYNC;
        fin_cnt   = '0;
      end else begin
        fin_shr = EXT_W'(jw);
      end
    end
    if (fin_phase == PH_SYNC) begin
      fin_ext  = '0;
      fin_shr  = '0;
      fin_done = 1'b0;
    end

    go_sync   = fin_phase == PH_SYNC;
    go_sample = (phase_q == PH_SEG1) && (fin_phase == PH_SEG2);
    phase_o   = phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
      ext_q   <= '0;
      shr_q   <= '0;
      done_q  <= 1'b0;
    end else if (tick) begin
      phase_q <= fin_phase;
      cnt_q   <= fin_cnt;
      ext_q   <= fin_ext;
      shr_q   <= fin_shr;
      done_q  <= fin_done;
    end
  end

endmodule

// File: rtl/can_bt_strobes.sv
module can_bt_strobes (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic go_sync,
  input  logic go_sample,
  input  logic level,
  output logic bit_start,
  output logic smp_strobe,
  output logic smp_bit
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_start  <= 1'b0;
      smp_strobe <= 1'b0;
      smp_bit    <= 1'b1;
    end else begin
      bit_start  <= tick & go_sync;
      smp_strobe <= tick & go_sample;
      if (tick && go_sample) smp_bit <= level;
    end
  end

endmodule

// File: rtl/can_bit_sync.sv
module can_bit_sync
  import can_bt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tq_tick,
  input  logic [SEG1_W-1:0] cfg_seg1,
  input  logic [SEG2_W-1:0] cfg_seg2,
  input  logic [SJW_W-1:0]  cfg_sjw,
  input  logic              cfg_triple,
  input  logic              rx,
  input  logic              sof_window,
  output logic              smp_strobe,
  output logic              smp_bit,
  output logic              bit_start
);

  logic      fall_w, level_w, go_sync_w, go_sample_w;
  bt_phase_e phase_w;

  can_bt_sampler u_sampler (
    .clk    (clk),
    .rst    (rst),
    .tick   (tq_tick),
    .rx     (rx),
    .triple (cfg_triple),
    .fall   (fall_w),
    .level  (level_w)
  );

  can_bt_phase #(
    .SEG1_W (SEG1_W),
    .SEG2_W (SEG2_W),
    .SJW_W  (SJW_W)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .tick      (tq_tick),
    .fall      (fall_w),
    .hard_ok   (sof_window),
    .cfg_seg1  (cfg_seg1),
    .cfg_seg2  (cfg_seg2),
    .cfg_sjw   (cfg_sjw),
    .go_sync   (go_sync_w),
    .go_sample (go_sample_w),
    .phase_o   (phase_w)
  );

  can_bt_strobes u_strobes (
    .clk        (clk),
    .rst        (rst),
    .tick       (tq_tick),
    .go_sync    (go_sync_w),
    .go_sample  (go_sample_w),
    .level      (level_w),
    .bit_start  (bit_start),
    .smp_strobe (smp_strobe),
    .smp_bit    (smp_bit)
  );

endmodule

// File: rtl/can_bit_sync_chk.sv
module can_bit_sync_chk
  import can_bt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tq_tick,
  input logic [SEG1_W-1:0] cfg_seg1,
  input logic [SEG2_W-1:0] cfg_seg2,
  input logic [SJW_W-1:0]  cfg_sjw,
  input logic              sof_window,
  input logic              smp_strobe,
  input logic              smp_bit,
  input logic              bit_start,
  input logic              fall,
  input bt_phase_e         phase
);

  localparam int QW = SEG1_W + 4;

  logic [QW-1:0] q_since, q_limit;

  always_comb begin
    q_limit = QW'(cfg_seg1) + QW'(cfg_seg2) + QW'(cfg_sjw) + QW'(4);
  end

  always_ff @(posedge clk) begin
    if (rst)            q_since <= '0;
    else if (bit_start) q_since <= QW'(tq_tick);
    else if (tq_tick)   q_since <= q_since + QW'(1);
  end

  // R11
  a_r11_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
    smp_strobe |-> $past(tq_tick));
  a_r11_start_after_tick: assert property (@(posedge clk) disable iff (rst)
    bit_start |-> $past(tq_tick));
  // R2
  a_r2_sample_not_at_start: assert property (@(posedge clk) disable iff (rst)
    !(smp_strobe && bit_start));
  a_r2_sample_leaves_seg1: assert property (@(posedge clk) disable iff (rst)
    smp_strobe |-> (phase == PH_SEG2) && ($past(phase) == PH_SEG1));
  // R10
  a_r10_bit_held: assert property (@(posedge clk) disable iff (rst)
    !smp_strobe |-> $stable(smp_bit));
  // R3
  a_r3_hard_sync: assert property (@(posedge clk) disable iff (rst)
    (tq_tick && sof_window && fall) |=> bit_start);
  // R5, R7: no bit exceeds nominal length plus one jump width
  a_r5_bit_length_bound: assert property (@(posedge clk) disable iff (rst)
    q_since <= q_limit);

endmodule

bind can_bit_sync can_bit_sync_chk #(
  .SEG1_W (SEG1_W),
  .SEG2_W (SEG2_W),
  .SJW_W  (SJW_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tq_tick    (tq_tick),
  .cfg_seg1   (cfg_seg1),
  .cfg_seg2   (cfg_seg2),
  .cfg_sjw    (cfg_sjw),
  .sof_window (sof_window),
  .smp_strobe (smp_strobe),
  .smp_bit    (smp_bit),
  .bit_start  (bit_start),
  .fall       (fall_w),
  .phase      (phase_w)
);

// File: tb/can_bit_sync_tb.sv
module can_bit_sync_tb;
  localparam int S1W = 3;
  localparam int S2W = 3;
  localparam int JWW = 2;
  localparam int NQ  = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst, tq_tick, cfg_triple, rx, sof_window;
  logic [S1W-1:0] cfg_seg1;
  logic [S2W-1:0] cfg_seg2;
  logic [JWW-1:0] cfg_sjw;
  logic           smp_strobe, smp_bit, bit_start;

  can_bit_sync #(.SEG1_W(S1W), .SEG2_W(S2W), .SJW_W(JWW)) u_dut (
    .clk(clk), .rst(rst), .tq_tick(tq_tick), .cfg_seg1(cfg_seg1),
    .cfg_seg2(cfg_seg2), .cfg_sjw(cfg_sjw), .cfg_triple(cfg_triple),
    .rx(rx), .sof_window(sof_window), .smp_strobe(smp_strobe),
    .smp_bit(smp_bit), .bit_start(bit_start)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic run_cfg(input int a, input int b, input int c, input int d);
    int s1, s2, jw, p, np, ext, shr, done, L, sp, r;
    logic prev, h2, cur, fall, rise, hs, rxv, expbit, es, bitv;
    string tag;
    s1 = a + 1; s2 = b + 1; jw = c + 1;
    cfg_seg1 = S1W'(a); cfg_seg2 = S2W'(b); cfg_sjw = JWW'(c); cfg_triple = d[0];
    rx = 1'b1; sof_window = 1'b0; tq_tick = 1'b0; rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    chk("R1", "bit_start", bit_start, 1'b0);
    chk("R1", "smp_strobe", smp_strobe, 1'b0);
    chk("R1", "smp_bit", smp_bit, 1'b1);
    p = 0; ext = 0; shr = 0; done = 0; prev = 1'b1; h2 = 1'b1; expbit = 1'b1; rxv = 1'b1;
    for (int q = 0; q < NQ; q++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0 || lfsr[2:0] == 3'd5) rxv = ~rxv;
      hs = (q < 4) || (lfsr[9:5] == 5'd0);
      cur = rxv;
      fall = prev && !cur;
      rise = !prev && cur;
      L = 1 + s1 + ext + s2 - shr;
      np = p + 1;
      if (np >= L) np = 0;
      tag = "R2";
      if (fall && hs) begin
        np = 0; tag = "R3";
      end else if (fall && np != 0 && done == 0) begin
        sp = 1 + s1 + ext;
        if (np < sp) begin
          ext = (np < jw) ? np : jw;
          tag = (np <= jw) ? "R4" : "R5";
        end else begin
          r = L - np;
          if (r <= jw) begin np = 0; tag = "R6"; end
          else begin shr = jw; tag = "R7"; end
        end
        done = 1;
      end else if (fall && np != 0) tag = "R8";
      else if (fall || rise) tag = "R9";
      if (np == 0) begin ext = 0; shr = 0; done = 0; end
      es = (np != 0) && (np == 1 + s1 + ext);
      bitv = d[0] ? ((cur & prev) | (cur & h2) | (prev & h2)) : cur;
      if (es) expbit = bitv;
      rx = rxv; sof_window = hs; tq_tick = 1'b1;
      @(posedge clk);
      @(negedge clk) tq_tick = 1'b0;
      chk(tag, "bit_start", bit_start, np == 0);
      chk(tag, "smp_strobe", smp_strobe, es);
      chk(es ? "R10" : tag, "smp_bit", smp_bit, expbit);
      @(posedge clk);
      @(negedge clk);
      // R11: one-cycle pulses
      chk("R11", "bit_start idle", bit_start, 1'b0);
      chk("R11", "smp_strobe idle", smp_strobe, 1'b0);
      h2 = prev; prev = cur; p = np;
    end
  endtask

  initial begin
    rst = 1'b1; tq_tick = 1'b0; rx = 1'b1; sof_window = 1'b0; cfg_triple = 1'b0;
    cfg_seg1 = '0; cfg_seg2 = '0; cfg_sjw = '0;
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 8; a++)
        for (int b = 1; b < 8; b++)
          for (int c = 0; c < 4; c++)
            if (c <= b && (d == 0 || b >= 2)) run_cfg(a, b, c, d);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule